// File: doc/BRIEF.md
# Occupancy-Based Thread Fetch Selector

This block decides, every cycle, which hardware thread of a simultaneous-multithreaded front end gets the next fetch slot. It keeps a private occupancy count per thread: the number of that thread's instructions currently held in the shared instruction window. The window reports each entry and each departure through per-thread pulses, and reports a per-thread flush. The selector offers the eligible thread with the smallest count. A thread that runs ahead therefore yields to threads that have drained, and a stalled thread cannot fill the window.

Two controls shape eligibility. Software marks a thread as low priority while it spins on a lock. Such a thread is only offered when no normal-priority thread is eligible. When more than one thread is active, each thread is limited to half of the window, so no single thread can take every entry. When exactly one thread is active, that thread may fill the whole window.

The offer is a valid/ready stream. `fetch_valid` and `fetch_tid` are computed from the current counts, masks and round-robin pointer, and do not wait for `fetch_ready`. An offer is consumed only on a cycle where valid and ready are both high. While ready is low, the selector's own state does not change. However, the offered thread can still change if the counts or masks change, because the offer is recomputed each cycle and is not held.

Top module: `smt_fetch_sel`

## Requirements
- R1: Synchronous active-low reset clears every occupancy count and sets the round-robin pointer to thread 0. In the first cycle after reset, with all threads active at normal priority, the offer is thread 0.
- R2: A thread's count rises by one on an enter pulse alone and falls by one on a leave pulse alone. An enter and a leave in the same cycle leave the count unchanged. The count saturates at the window depth and at zero.
- R3: A flush pulse sets that thread's count to zero on the next clock edge, overriding any enter or leave pulse in the same cycle.
- R4: `fetch_valid` is high exactly when at least one thread is eligible. A thread is eligible when it is active and its count is below its cap. An inactive thread is never offered.
- R5: Among the candidates of the chosen priority class, the offered thread has the smallest occupancy count.
- R6: A thread flagged low priority is offered only when no normal-priority thread is eligible.
- R7: When two or more threads are active, the cap is WIN_DEPTH/2. A thread whose count has reached this cap is not eligible.
- R8: When exactly one thread is active, its cap is WIN_DEPTH. It stays eligible until the window holds WIN_DEPTH of its instructions.
- R9: Ties in count are resolved in favour of the first candidate at or after the round-robin pointer, in ascending thread order with wrap. After a handshake (valid and ready both high) on thread t, the pointer becomes t+1, modulo the thread count.
- R10: While `fetch_ready` is low, the round-robin pointer does not move. With counts and masks also unchanged, the offer stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_enter | input | NUM_THREADS | Per-thread pulse: one instruction entered the window |
| win_leave | input | NUM_THREADS | Per-thread pulse: one instruction left the window |
| win_flush | input | NUM_THREADS | Per-thread pulse: all of the thread's window entries are discarded |
| thr_active | input | NUM_THREADS | Per-thread active mask |
| thr_lowpri | input | NUM_THREADS | Per-thread low-priority (lock spinning) flag |
| fetch_ready | input | 1 | Fetch stage accepts the offered thread |
| fetch_valid | output | 1 | A thread is offered |
| fetch_tid | output | $clog2(NUM_THREADS) | Offered thread number |

## Verification
Some properties are checked on every cycle by the assertions. These are: the offered thread is active; it respects the shared-window cap; no lower-count candidate of its class exists; a low-priority offer implies no normal thread is eligible; every flush empties the count on the next edge; and counts never exceed the depth. Other behaviours can only be shown by the bench's scenarios, driven against a reference model. These are: the exact round-robin order among equal counts; the pointer freezing under back-pressure; saturation at both ends; and the switch between the full-window and half-window cap as the active mask changes.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;

  // Distance from base to idx going upward around a ring of n slots.
  function automatic int ring_dist(input int idx, input int base, input int n);
    return (idx >= base) ? (idx - base) : (idx + n - base);
  endfunction

  // Slot following idx on a ring of n slots.
  function automatic int ring_next(input int idx, input int n);
    return (idx == n - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/smt_occ_counter.sv
module smt_occ_counter #(
  parameter int WIN_DEPTH = 16,
  localparam int CW = $clog2(WIN_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter,
  input  logic          leave,
  input  logic          flush,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL = CW'(WIN_DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (enter && !leave && count != FULL) begin
      count <= count + 1'b1;
    end else if (leave && !enter && count != '0) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/smt_elig_gate.sv
module smt_elig_gate #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 16,
  localparam int CW = $clog2(WIN_DEPTH + 1),
  localparam int AW = $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS-1:0]    active,
  input  logic [NUM_THREADS-1:0]    lowpri,
  input  logic [NUM_THREADS*CW-1:0] counts,
  output logic [NUM_THREADS-1:0]    elig_norm,
  output logic [NUM_THREADS-1:0]    elig_low
);

  localparam logic [CW-1:0] CAP_ALONE  = CW'(WIN_DEPTH);
  localparam logic [CW-1:0] CAP_SHARED = CW'(WIN_DEPTH / 2);

  logic [AW-1:0] n_act;
  logic          shared;
  logic [CW-1:0] cap;

  always_comb begin
    n_act = '0;
    for (int t = 0; t < NUM_THREADS; t++) n_act = n_act + AW'(active[t]);
  end

  assign shared = (n_act > AW'(1));
  assign cap    = shared ? CAP_SHARED : CAP_ALONE;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_gate
    logic room;
    assign room         = counts[t*CW +: CW] < cap;
    assign elig_norm[t] = active[t] & ~lowpri[t] & room;
    assign elig_low[t]  = active[t] &  lowpri[t] & room;
  end

endmodule

// File: rtl/smt_min_pick.sv
module smt_min_pick #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 16,
  localparam int CW   = $clog2(WIN_DEPTH + 1),
  localparam int TIDW = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0]    cand,
  input  logic [NUM_THREADS*CW-1:0] counts,
  input  logic [TIDW-1:0]           rr_ptr,
  output logic                      found,
  output logic [TIDW-1:0]           tid
);

  import smt_fetch_pkg::*;

  // Key is (count, distance from pointer); smallest key wins.
  always_comb begin
    logic [CW-1:0] best_cnt;
    int            best_dist;
    found     = 1'b0;
    tid       = '0;
    best_cnt  = '0;
    best_dist = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic [CW-1:0] c;
      int            d;
      c = counts[t*CW +: CW];
      d = ring_dist(t, int'(rr_ptr), NUM_THREADS);
      if (cand[t] && (!found || c < best_cnt || (c == best_cnt && d < best_dist))) begin
        found     = 1'b1;
        tid       = TIDW'(t);
        best_cnt  = c;
        best_dist = d;
      end
    end
  end

endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 16,
  localparam int CW   = $clog2(WIN_DEPTH + 1),
  localparam int TIDW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] win_enter,
  input  logic [NUM_THREADS-1:0] win_leave,
  input  logic [NUM_THREADS-1:0] win_flush,
  input  logic [NUM_THREADS-1:0] thr_active,
  input  logic [NUM_THREADS-1:0] thr_lowpri,
  input  logic                   fetch_ready,
  output logic                   fetch_valid,
  output logic [TIDW-1:0]        fetch_tid
);

  import smt_fetch_pkg::*;

  logic [NUM_THREADS*CW-1:0] cnt_flat;
  logic [NUM_THREADS-1:0]    elig_norm, elig_low;
  logic                      found_norm, found_low;
  logic [TIDW-1:0]           tid_norm, tid_low;
  logic [TIDW-1:0]           rr_ptr;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_occ
    smt_occ_counter #(.WIN_DEPTH(WIN_DEPTH)) occ_i (
      .clk   (clk),
      .rst_n (rst_n),
      .enter (win_enter[t]),
      .leave (win_leave[t]),
      .flush (win_flush[t]),
      .count (cnt_flat[t*CW +: CW])
    );
  end

  smt_elig_gate #(.NUM_THREADS(NUM_THREADS), .WIN_DEPTH(WIN_DEPTH)) gate_i (
    .active    (thr_active),
    .lowpri    (thr_lowpri),
    .counts    (cnt_flat),
    .elig_norm (elig_norm),
    .elig_low  (elig_low)
  );

  smt_min_pick #(.NUM_THREADS(NUM_THREADS), .WIN_DEPTH(WIN_DEPTH)) pick_norm_i (
    .cand   (elig_norm),
    .counts (cnt_flat),
    .rr_ptr (rr_ptr),
    .found  (found_norm),
    .tid    (tid_norm)
  );

  smt_min_pick #(.NUM_THREADS(NUM_THREADS), .WIN_DEPTH(WIN_DEPTH)) pick_low_i (
    .cand   (elig_low),
    .counts (cnt_flat),
    .rr_ptr (rr_ptr),
    .found  (found_low),
    .tid    (tid_low)
  );

  assign fetch_valid = found_norm | found_low;
  assign fetch_tid   = found_norm ? tid_norm : tid_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fetch_valid && fetch_ready) begin
      rr_ptr <= TIDW'(ring_next(int'(fetch_tid), NUM_THREADS));
    end
  end

endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 16,
  localparam int CW   = $clog2(WIN_DEPTH + 1),
  localparam int TIDW = $clog2(NUM_THREADS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_THREADS-1:0]    win_flush,
  input logic [NUM_THREADS-1:0]    thr_active,
  input logic [NUM_THREADS-1:0]    thr_lowpri,
  input logic                      fetch_valid,
  input logic [TIDW-1:0]           fetch_tid,
  input logic [NUM_THREADS*CW-1:0] cnt_flat
);

  logic [CW-1:0]          sel_cnt;
  logic                   sel_low;
  logic                   multi;
  logic [CW-1:0]          lim;
  logic [NUM_THREADS-1:0] norm_ok;
  logic                   smaller_exists;

  assign sel_cnt = cnt_flat[fetch_tid*CW +: CW];
  assign sel_low = thr_lowpri[fetch_tid];
  assign multi   = $countones(thr_active) > 1;
  assign lim     = multi ? CW'(WIN_DEPTH / 2) : CW'(WIN_DEPTH);

  always_comb begin
    smaller_exists = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      norm_ok[t] = thr_active[t] && !thr_lowpri[t] && (cnt_flat[t*CW +: CW] < lim);
      if (thr_active[t] && (thr_lowpri[t] == sel_low) &&
          (cnt_flat[t*CW +: CW] < lim) && (cnt_flat[t*CW +: CW] < sel_cnt))
        smaller_exists = 1'b1;
    end
  end

  p_offer_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> thr_active[fetch_tid]);

  p_min_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !smaller_exists);

  p_low_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && sel_low) |-> (norm_ok == '0));

  p_shared_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && multi) |-> (sel_cnt < CW'(WIN_DEPTH / 2)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    p_flush_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_flush[t] |=> (cnt_flat[t*CW +: CW] == '0));
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[t*CW +: CW] <= CW'(WIN_DEPTH));
  end

endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(
  .NUM_THREADS (NUM_THREADS),
  .WIN_DEPTH   (WIN_DEPTH)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_flush   (win_flush),
  .thr_active  (thr_active),
  .thr_lowpri  (thr_lowpri),
  .fetch_valid (fetch_valid),
  .fetch_tid   (fetch_tid),
  .cnt_flat    (cnt_flat)
);

// File: tb/smt_fetch_sel_tb_top.sv
module smt_fetch_sel_tb_top;

  localparam int NT   = 4;
  localparam int WIN  = 8;
  localparam int TIDW = $clog2(NT);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NT-1:0]   win_enter, win_leave, win_flush, thr_active, thr_lowpri;
  logic            fetch_ready;
  logic            fetch_valid;
  logic [TIDW-1:0] fetch_tid;

  always #5 clk = ~clk;

  smt_fetch_sel #(.NUM_THREADS(NT), .WIN_DEPTH(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .win_enter(win_enter), .win_leave(win_leave), .win_flush(win_flush),
    .thr_active(thr_active), .thr_lowpri(thr_lowpri),
    .fetch_ready(fetch_ready), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state
  int m_cnt[NT];
  int m_rr;

  function automatic int pick(input bit want_low, input int lim);
    int best = -1;
    for (int k = 0; k < NT; k++) begin
      int t = (m_rr + k) % NT;
      if (thr_active[t] && (thr_lowpri[t] == want_low) && m_cnt[t] < lim)
        if (best < 0 || m_cnt[t] < m_cnt[best]) best = t;
    end
    return best;
  endfunction

  task automatic step(input string tag);
    int  n_act = 0;
    int  lim, sel;
    bit  ev;
    #1;
    for (int t = 0; t < NT; t++) n_act += thr_active[t];
    lim = (n_act > 1) ? WIN / 2 : WIN;
    sel = pick(1'b0, lim);
    if (sel < 0) sel = pick(1'b1, lim);
    ev = (sel >= 0);
    n_tests++;
    if (fetch_valid !== ev || (ev && int'(fetch_tid) != sel)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
               tag, fetch_valid, fetch_tid, ev, sel);
    end
    // advance model
    for (int t = 0; t < NT; t++) begin
      if (win_flush[t]) m_cnt[t] = 0;
      else if (win_enter[t] && !win_leave[t] && m_cnt[t] < WIN) m_cnt[t]++;
      else if (win_leave[t] && !win_enter[t] && m_cnt[t] > 0) m_cnt[t]--;
    end
    if (ev && fetch_ready) m_rr = (sel + 1) % NT;
    @(posedge clk);
    @(negedge clk);
    win_enter = '0; win_leave = '0; win_flush = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst_n = 1'b0; win_enter = '0; win_leave = '0; win_flush = '0;
    thr_active = '0; thr_lowpri = '0; fetch_ready = 1'b1;
    for (int t = 0; t < NT; t++) m_cnt[t] = 0;
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all active, offer thread 0
    thr_active = '1;
    step("R1");
    // R9: equal counts rotate 1,2,3,0
    for (int i = 0; i < 4; i++) step("R9");
    // R2: thread 0 gains two entries; R5 then avoids it
    win_enter = 4'b0001; step("R2");
    win_enter = 4'b0001; step("R2");
    win_enter = 4'b0001; win_leave = 4'b0001; step("R2");
    for (int i = 0; i < 4; i++) step("R5");
    // R8: thread 0 alone fills the whole window, then saturates
    thr_active = 4'b0001;
    for (int i = 0; i < 9; i++) begin win_enter = 4'b0001; step("R8"); end
    step("R8");
    // R7: second thread active, thread 0 over the shared cap
    thr_active = 4'b0011;
    step("R7");
    for (int i = 0; i < 4; i++) begin win_enter = 4'b0010; step("R7"); end
    step("R7");
    // R3: flush overrides enter
    win_flush = 4'b0001; win_enter = 4'b0001; step("R3");
    step("R3");
    // R6: thread 0 low priority; thread 1 capped so thread 0 offered
    thr_lowpri = 4'b0001; step("R6");
    win_leave = 4'b0010; step("R6");
    step("R6");
    thr_lowpri = '0;
    // R4: nothing active
    thr_active = '0; step("R4");
    // R10: back-pressure keeps the pointer
    thr_active = '1; fetch_ready = 1'b0;
    for (int i = 0; i < 4; i++) step("R10");
    fetch_ready = 1'b1; step("R10");
    // R2: drain with leaves to zero and beyond
    thr_active = '1;
    for (int i = 0; i < 10; i++) begin win_leave = '1; step("R2"); end

    // Sweep over all active and low-priority masks with LFSR traffic
    for (int k = 0; k < 16384; k++) begin
      thr_active  = 4'(k >> 6);
      thr_lowpri  = 4'(k >> 10);
      win_enter   = lfsr[3:0];
      win_leave   = ((k >> 5) & 1) ? (lfsr[7:4] | lfsr[11:8]) : (lfsr[7:4] & lfsr[11:8]);
      win_flush   = (lfsr[14:12] == 3'd0) ? 4'(1 << lfsr[9:8]) : 4'd0;
      fetch_ready = lfsr[10] | lfsr[15];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (thr_lowpri != '0) step("R6");
      else step("R5");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule